// File: doc/BRIEF.md
# Grouped GPIO Interrupt Service Encoder

This block watches up to nine groups of sixteen GPIO interrupt lines. Each line passes through a two-flop synchroniser. A 4-bit trigger code, shared by a run of four adjacent lines, selects level or edge detection for that line. A detected event latches into a per-line pending bit. A per-line mask bit keeps a pending line away from the single combined interrupt output. Software clears pending bits by writing ones to them.

The block also offers a read-only service word. This word names one pending, unmasked line by its group number and its line number. A handler reads the service word, services the line it names, clears that pending bit and reads the word again, until the group field is zero. The register file is laid out in pairs: two groups share each 32-bit word of the configuration, mask and pending banks, and the odd group sits in the upper half.

Top module: `gpio_irq_svc_enc`

## Requirements
- R1: After reset every mask bit reads 1, every pending and configuration bit reads 0, `irq_o` is low and the service word reads 0.
- R2: Byte address bits [6:5] select the bank (0 configuration, 1 mask, 2 pending, 3 service). Group k (counted from 0) lives in the word at byte offset 4*(k/2) within its bank: bits [15:0] for even k and bits [31:16] for odd k. The configuration and mask words read back what was written.
- R3: Within a group, configuration bits [4j+3:4j] hold the trigger code for lines 4j to 4j+3. All four of those lines use that code.
- R4: Trigger codes: 0 sets pending while the line is low, 1 while it is high, 2 on a falling edge, 4 on a rising edge, 6 on either edge. Every other code never sets pending.
- R5: An edge-detected pending bit stays set after its input returns. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R6: While a level condition that sets pending persists, a clear write does not remove the bit. When detection and a clear fall in the same cycle, detection wins.
- R7: A set mask bit keeps its line out of `irq_o` and out of the service word, while the pending bit still records events.
- R8: `irq_o` is high exactly when some pending bit has its mask bit clear.
- R9: The service word (byte address 0x60) carries bits [7:4] = group index + 1 and bits [3:0] = line number. It names the lowest group that has a pending unmasked line, and the lowest such line within that group. It reads 0 when no such line exists.
- R10: A level change on a pin shows in its pending bit after exactly three rising clock edges (two synchroniser flops plus the pending flop), and not after two.
- R11: Writes to the service word have no effect. Accesses with byte address bits [1:0] nonzero are ignored and read 0. The upper half of the last word, which has no group when the group count is odd, reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_GROUPS*16 (144) | Raw interrupt lines, group k at bits [16k+15:16k] |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 7 | Byte address for both read and write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A corrupted pending or mask flop shows up on `irq_o` and in the service word in the same cycle, because both are combinational views of that state. The service-word sweep clears one named line at a time, so a wrong priority order or encoding appears on the next read. A misplaced trigger selector or a wrong code decode changes which pending bits a controlled pin pattern sets, and this is visible three edges after the pin moves. An off-by-one in the synchroniser depth shows up as a pending bit that is early or late at the sampled edge.

// File: rtl/gisr_pkg.sv
package gisr_pkg;

    localparam int LINES  = 16;
    localparam int SEL_W  = 4;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int WIDX_W = 3;
    localparam int GRP_W  = 4;
    localparam int LINE_W = $clog2(LINES);

    typedef enum logic [SEL_W-1:0] {
        TRIG_LOW  = 4'd0,
        TRIG_HIGH = 4'd1,
        TRIG_FALL = 4'd2,
        TRIG_RISE = 4'd4,
        TRIG_BOTH = 4'd6
    } trig_e;

    typedef enum logic [1:0] {
        BANK_CFG  = 2'd0,
        BANK_MASK = 2'd1,
        BANK_PEND = 2'd2,
        BANK_SVC  = 2'd3
    } bank_e;

    typedef struct packed {
        bank_e              bank;
        logic [WIDX_W-1:0]  widx;
        logic [1:0]         byte_off;
    } addr_t;

    typedef struct packed {
        logic [GRP_W-1:0]  grp;
        logic [LINE_W-1:0] line;
    } svc_t;

    typedef struct packed {
        logic [LINES-1:0] cfg;
        logic [LINES-1:0] mask;
        logic [LINES-1:0] pend;
    } grp_regs_t;

    // Decide whether a line with the given code raises an event this cycle.
    function automatic logic trig_fire(logic [SEL_W-1:0] code, logic cur, logic prev);
        logic hit;
        case (code)
            TRIG_LOW:  hit = !cur;
            TRIG_HIGH: hit = cur;
            TRIG_FALL: hit = prev && !cur;
            TRIG_RISE: hit = !prev && cur;
            TRIG_BOTH: hit = prev != cur;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Index of the least significant set bit; zero when none is set.
    function automatic logic [LINE_W-1:0] lowest_set(logic [LINES-1:0] v);
        logic [LINE_W-1:0] r;
        r = '0;
        for (int l = LINES - 1; l >= 0; l--) begin
            if (v[l]) r = LINE_W'(l);
        end
        return r;
    endfunction

endpackage

// File: rtl/gisr_sync.sv
module gisr_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;
    logic [W-1:0] last;

    // Idle-high lines: reset to ones so no false edge or low level follows reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '1;
            stage2 <= '1;
            last   <= '1;
        end else begin
            stage1 <= pins;
            stage2 <= stage1;
            last   <= stage2;
        end
    end

    assign cur  = stage2;
    assign prev = last;
endmodule

// File: rtl/gisr_group.sv
module gisr_group
    import gisr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] cur,
    input  logic [LINES-1:0] prev,
    input  logic             cfg_we,
    input  logic             mask_we,
    input  logic             clr_we,
    input  logic [LINES-1:0] wdata,
    output grp_regs_t        regs
);
    logic [LINES-1:0] cfg_q;
    logic [LINES-1:0] mask_q;
    logic [LINES-1:0] pend_q;
    logic [LINES-1:0] fire;
    logic [LINES-1:0] clr_bits;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        localparam int SEL_LSB = SEL_W * (l / 4);
        assign fire[l] = trig_fire(cfg_q[SEL_LSB +: SEL_W], cur[l], prev[l]);
    end

    assign clr_bits = clr_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            if (cfg_we)  cfg_q  <= wdata;
            if (mask_we) mask_q <= wdata;
            // A fresh event outranks a clear in the same cycle.
            pend_q <= (pend_q & ~clr_bits) | fire;
        end
    end

    assign regs.cfg  = cfg_q;
    assign regs.mask = mask_q;
    assign regs.pend = pend_q;
endmodule

// File: rtl/gisr_prio.sv
module gisr_prio
    import gisr_pkg::*;
#(
    parameter int NUM_GROUPS = 9
) (
    input  logic [NUM_GROUPS*LINES-1:0] act,
    output svc_t                        svc
);
    always_comb begin
        svc = '0;
        // Walk from the top down so the lowest active group is the last to be written.
        for (int k = NUM_GROUPS - 1; k >= 0; k--) begin
            if (|act[k*LINES +: LINES]) begin
                svc.grp  = GRP_W'(k + 1);
                svc.line = lowest_set(act[k*LINES +: LINES]);
            end
        end
    end
endmodule

// File: rtl/gpio_irq_svc_enc.sv
module gpio_irq_svc_enc
    import gisr_pkg::*;
#(
    parameter int NUM_GROUPS = 9
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_GROUPS*LINES-1:0] pins_i,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           rdata_o,
    output logic                        irq_o
);
    localparam int NL        = NUM_GROUPS * LINES;
    localparam int NUM_WORDS = (NUM_GROUPS + 1) / 2;

    addr_t            acc;
    logic             aligned;
    logic [NL-1:0]    cur_all;
    logic [NL-1:0]    prev_all;
    logic [NL-1:0]    pend_all;
    logic [NL-1:0]    mask_all;
    logic [NL-1:0]    act_all;
    grp_regs_t        regs [NUM_GROUPS];
    svc_t             svc;

    assign acc     = addr_i;
    assign aligned = acc.byte_off == 2'b00;

    gisr_sync #(.W(NL)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .pins (pins_i),
        .cur  (cur_all),
        .prev (prev_all)
    );

    for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
        localparam logic [WIDX_W-1:0] WORD = WIDX_W'(k / 2);
        localparam int                HALF = (k % 2) * LINES;
        logic word_wr;

        assign word_wr = wr_en_i && aligned && (acc.widx == WORD);

        gisr_group u_grp (
            .clk     (clk),
            .rst     (rst),
            .cur     (cur_all[k*LINES +: LINES]),
            .prev    (prev_all[k*LINES +: LINES]),
            .cfg_we  (word_wr && acc.bank == BANK_CFG),
            .mask_we (word_wr && acc.bank == BANK_MASK),
            .clr_we  (word_wr && acc.bank == BANK_PEND),
            .wdata   (wdata_i[HALF +: LINES]),
            .regs    (regs[k])
        );

        assign pend_all[k*LINES +: LINES] = regs[k].pend;
        assign mask_all[k*LINES +: LINES] = regs[k].mask;
    end

    assign act_all = pend_all & ~mask_all;
    assign irq_o   = |act_all;

    gisr_prio #(.NUM_GROUPS(NUM_GROUPS)) u_prio (
        .act (act_all),
        .svc (svc)
    );

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            if (acc.bank == BANK_SVC) begin
                rdata_o = DATA_W'(svc);
            end else if (int'(acc.widx) < NUM_WORDS) begin
                for (int k = 0; k < NUM_GROUPS; k++) begin
                    if (int'(acc.widx) == k / 2) begin
                        case (acc.bank)
                            BANK_CFG:  rdata_o[(k%2)*LINES +: LINES] = regs[k].cfg;
                            BANK_MASK: rdata_o[(k%2)*LINES +: LINES] = regs[k].mask;
                            default:   rdata_o[(k%2)*LINES +: LINES] = regs[k].pend;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gisr_checker.sv
module gisr_checker
    import gisr_pkg::*;
#(
    parameter int NUM_GROUPS = 9
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        wr_en_i,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [DATA_W-1:0]           wdata_i,
    input logic                        irq_o,
    input svc_t                        svc,
    input logic [NUM_GROUPS*LINES-1:0] pend_all,
    input logic [NUM_GROUPS*LINES-1:0] mask_all
);
    localparam int NL = NUM_GROUPS * LINES;

    logic [NL-1:0] act;
    logic          named_active;
    logic          nothing_below;

    assign act = pend_all & ~mask_all;

    always_comb begin
        int idx;
        named_active  = 1'b0;
        nothing_below = 1'b1;
        idx = (int'(svc.grp) - 1) * LINES + int'(svc.line);
        if (svc.grp != '0 && idx < NL) begin
            named_active = act[idx];
            for (int i = 0; i < NL; i++) begin
                if (i < idx && act[i]) nothing_below = 1'b0;
            end
        end
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((&mask_all) && (pend_all == '0) && !irq_o));

    p_mask_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == 7'h20) |=> (mask_all[31:0] == $past(wdata_i)));

    p_clear_only_by_write_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(pend_all[0]) |-> $past(wr_en_i && addr_i == 7'h40 && wdata_i[0]));

    p_all_masked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (&mask_all) |-> !irq_o);

    p_irq_agrees_svc_r8: assert property (@(posedge clk) disable iff (rst)
        irq_o == (svc.grp != '0));

    p_svc_names_active_r9: assert property (@(posedge clk) disable iff (rst)
        (svc.grp != '0) |-> (named_active && nothing_below));
endmodule

bind gpio_irq_svc_enc gisr_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .svc      (svc),
    .pend_all (pend_all),
    .mask_all (mask_all)
);

// File: tb/gpio_irq_svc_enc_bench.sv
`timescale 1ns/1ps
module gpio_irq_svc_enc_bench;
    import gisr_pkg::*;

    localparam int NG = 9;
    localparam int NL = NG * LINES;
    localparam int NW = (NG + 1) / 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] pins;
    logic          wr_en;
    logic [6:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    gpio_irq_svc_enc #(.NUM_GROUPS(NG)) u_gpio_irq_svc_enc (
        .clk     (clk),
        .rst     (rst),
        .pins_i  (pins),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all_pend();
        for (int w = 0; w < NW; w++) wr(7'(8'h40 + 4 * w), 32'hFFFF_FFFF);
    endtask

    function automatic logic exp_line(input int code, input logic a, input logic b);
        case (code)
            0:       return !a || !b;
            1:       return a || b;
            2:       return a && !b;
            4:       return !a && b;
            6:       return a != b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_svc(input logic [NL-1:0] p, input logic [NL-1:0] m);
        logic [7:0] r;
        r = '0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (p[i] && !m[i]) r = {4'(i / LINES + 1), 4'(i % LINES)};
        end
        return r;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0]    d;
        logic [15:0]    e16;
        logic [NL-1:0]  mp;
        logic [NL-1:0]  mm;
        logic [159:0]   mpad;
        logic [7:0]     es;
        int             codes [10];
        int             idx;

        codes = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 15};
        pins  = '1;
        wr_en = 1'b0;
        addr  = '0;
        wdata = '0;
        idle(3);
        rst = 1'b0;

        // R1: reset state of every word
        for (int w = 0; w < NW; w++) begin
            rd(7'(4 * w), d);          chk("R1 cfg", d, 32'h0);
            rd(7'(8'h20 + 4 * w), d);  chk("R1 mask", d, (w == NW - 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF);
            rd(7'(8'h40 + 4 * w), d);  chk("R1 pend", d, 32'h0);
        end
        rd(7'h60, d); chk("R1 svc", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 / R11: word layout and the missing upper half of the last word
        for (int w = 0; w < NW; w++) begin
            wr(7'(8'h20 + 4 * w), {16'(16'h1000 + w), 16'(16'h0100 + w)});
            wr(7'(4 * w), {16'(16'h3000 + w), 16'(16'h0300 + w)});
        end
        for (int w = 0; w < NW; w++) begin
            rd(7'(8'h20 + 4 * w), d);
            chk("R2 mask", d, {(w == NW - 1) ? 16'h0 : 16'(16'h1000 + w), 16'(16'h0100 + w)});
            rd(7'(4 * w), d);
            chk("R2 cfg", d, {(w == NW - 1) ? 16'h0 : 16'(16'h3000 + w), 16'(16'h0300 + w)});
        end
        wr(7'h01, 32'hFFFF_FFFF);
        rd(7'h00, d); chk("R11 misaligned write", d, {16'h3000, 16'h0300});
        rd(7'h21, d); chk("R11 misaligned read", d, 32'h0);
        for (int w = 0; w < NW; w++) begin
            wr(7'(4 * w), 32'h0);
            wr(7'(8'h20 + 4 * w), 32'hFFFF_FFFF);
        end
        idle(5);
        clear_all_pend();

        // R10: three edges from pin to pending
        wr(7'h00, 32'h0000_0002);
        wr(7'h40, 32'hFFFF_FFFF);
        pins[0] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(7'h40, d); chk("R10 after two edges", d, 32'h0);
        @(posedge clk); @(negedge clk);
        rd(7'h40, d); chk("R10 after three edges", d, 32'h1);
        pins[0] = 1'b1;
        idle(5);
        wr(7'h00, 32'h0);
        clear_all_pend();

        // R3 / R4: every code, both starting levels, on group 2 lines 4-7
        for (int c = 0; c < 10; c++) begin
            for (int a = 0; a < 2; a++) begin
                wr(7'h04, {16'h0000, 16'hFF0F | 16'(codes[c] << 4)});
                pins[47:32] = {16{1'(a)}};
                idle(5);
                wr(7'h44, 32'hFFFF_FFFF);
                idle(2);
                pins[37] = ~1'(a);
                idle(5);
                rd(7'h44, d);
                e16 = '0;
                for (int l = 4; l < 8; l++) begin
                    e16[l] = exp_line(codes[c], 1'(a), (l == 5) ? ~1'(a) : 1'(a));
                end
                chk($sformatf("R3 R4 code %0d start %0d", codes[c], a), d, {16'h0, e16});
                chk("R7 masked lines keep irq low", {31'h0, irq}, 32'h0);
            end
        end
        pins = '1;
        wr(7'h04, 32'h0);
        idle(5);
        clear_all_pend();

        // R6: persisting level beats the clear
        wr(7'h00, 32'h0000_0001);
        idle(5);
        rd(7'h40, d); chk("R6 level high set", d, 32'h0000_000F);
        wr(7'h40, 32'hFFFF_FFFF);
        rd(7'h40, d); chk("R6 clear under level", d, 32'h0000_000F);
        wr(7'h00, 32'h0000_0002);
        wr(7'h40, 32'hFFFF_FFFF);
        rd(7'h40, d); chk("R6 clear after level dropped", d, 32'h0);

        // R5: edge pending latches, W1C
        pins[0] = 1'b0;
        idle(5);
        pins[0] = 1'b1;
        idle(5);
        rd(7'h40, d); chk("R5 latched after pulse", d, 32'h1);
        wr(7'h40, 32'h0);
        rd(7'h40, d); chk("R5 write zero keeps", d, 32'h1);
        wr(7'h40, 32'h1);
        rd(7'h40, d); chk("R5 write one clears", d, 32'h0);

        // R9 / R8 / R7: one-at-a-time servicing
        for (int w = 0; w < NW; w++) wr(7'(4 * w), 32'h2222_2222);
        clear_all_pend();
        mp = '0;
        mm = '0;
        mm[5*16+7] = 1'b1;
        for (int j = 0; j < 6; j++) begin
            case (j)
                0:       idx = 8*16 + 15;
                1:       idx = 3*16 + 9;
                2:       idx = 3*16 + 2;
                3:       idx = 0;
                4:       idx = 5*16 + 7;
                default: idx = 1*16 + 8;
            endcase
            pins[idx] = 1'b0;
            idle(5);
            pins = '1;
            idle(5);
            mp[idx] = 1'b1;
        end
        mpad = '0;
        mpad[NL-1:0] = mm;
        for (int w = 0; w < NW; w++) wr(7'(8'h20 + 4 * w), mpad[w*32 +: 32]);
        for (int it = 0; it < 10; it++) begin
            es = exp_svc(mp, mm);
            rd(7'h60, d);
            chk("R9 service word", d, {24'h0, es});
            chk("R8 irq level", {31'h0, irq}, {31'h0, es != 8'h0});
            if (es == 8'h0) break;
            idx = (int'(es[7:4]) - 1) * 16 + int'(es[3:0]);
            wr(7'(8'h40 + 4 * (idx / 32)), 32'h1 << (idx % 32));
            mp[idx] = 1'b0;
        end
        rd(7'h48, d); chk("R7 masked pending kept", d, 32'h0080_0000);
        chk("R7 masked irq low", {31'h0, irq}, 32'h0);
        wr(7'h28, 32'h0);
        rd(7'h60, d); chk("R9 unmasked group 6 line 7", d, 32'h67);
        chk("R8 irq after unmask", {31'h0, irq}, 32'h1);
        wr(7'h60, 32'h0);
        rd(7'h60, d); chk("R11 service write ignored", d, 32'h67);
        wr(7'h48, 32'h0080_0000);
        rd(7'h60, d); chk("R9 empty", d, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule